// File: doc/BRIEF.md
# Angular-Rate Sensor Register Bank

This block is the byte-wide register bank that sits behind the serial port of a three-axis angular-rate sensor. The I2C or SPI shift logic lives outside it and presents each transferred byte as one access cycle. An access cycle carries an enable, a write flag, a start flag and an address. On a start cycle the supplied address is used. On any later cycle the block uses its internal burst pointer, so a host can read or write a run of consecutive registers after sending a single address.

The bank holds the live status byte, the three 16-bit two's complement axis samples (exposed as six bytes, most significant byte first), a fixed identity byte and three control registers. The control fields drive the sensing datapath through dedicated outputs. When a burst reaches the last output byte, the read pointer wraps either to the status register or to the first data byte, depending on a control bit. When external power control is enabled, the second interrupt pin turns into a level-sensitive input. Through a synchronizer, that pin then owns the active/standby bit.

Top module: `gyro_regbank`

## Requirements
- R1: After reset, control registers 0, 1 and 3 all read 0x00, `int2_oe` is 1 and every control output is 0.
- R2: A read of the identity register at 0x0C returns 0xD6.
- R3: The status byte is read at 0x00. The axis data occupies 0x01 to 0x06 in the order X high, X low, Y high, Y low, Z high, Z low. `sample_in` holds X in bits 47:32, Y in 31:16 and Z in 15:0.
- R4: After each read, the pointer advances by one. The exception is after reading 0x06 with control register 3 bit 3 clear, when the next pointer-addressed read is 0x00. After a write, the pointer advances by one.
- R5: With control register 3 bit 3 set, the read that follows a read of 0x06 uses 0x01, so a burst loops over the data bytes only.
- R6: Reading 0x01 returns the live X high byte and captures all six data bytes. Reads of 0x02 to 0x06 return that captured copy, even if `sample_in` changes in between.
- R7: Control register 0 at 0x0D is read/write with these fields: bits 7:6 bandwidth select (`bw_sel`), bit 5 SPI wire mode (`spi_wire`), bits 4:3 auxiliary select (`aux_sel`), bit 2 high-pass enable (`hpf_en`) and bits 1:0 range select (`fs_sel`). It changes only when written.
- R8: Control register 3 at 0x15 stores bit 3 (pointer wrap-to-data), bit 2 (external power control) and bit 0 (range doubling, `fsr_dbl`). Its other bits read 0.
- R9: While control register 3 bit 2 is 1, `int2_oe` is 0 and `dev_active` follows `int2_pin_in` three clock edges after the pin changes. Host writes to the active bit are ignored during this time.
- R10: While control register 3 bit 2 is 0, `int2_oe` is 1, `int2_out` equals `irq2_req`, and the active bit is written by the host.
- R11: Reads of any address outside 0x00–0x06, 0x0C, 0x0D, 0x13 and 0x15 return 0x00. Writes to those addresses, and to 0x00–0x06 and 0x0C, change nothing.
- R12: Control register 1 at 0x13 holds the ready bit at bit 0, the active bit at bit 1 and the 3-bit data-rate select at bits 4:2 (`odr_sel`). Bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | One byte access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_start | input | 1 | Use `bus_addr` rather than the burst pointer |
| bus_addr | input | 8 | Register address on start cycles |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered, valid after the access edge |
| stat_in | input | 8 | Live status byte |
| sample_in | input | 48 | Live axis samples X, Y, Z |
| irq2_req | input | 1 | Interrupt request routed to the second interrupt pin |
| int2_pin_in | input | 1 | Level on the second interrupt pin |
| int2_oe | output | 1 | Output enable for the second interrupt pin |
| int2_out | output | 1 | Value driven on the second interrupt pin |
| bw_sel | output | 2 | Bandwidth select |
| spi_wire | output | 1 | SPI wire mode |
| aux_sel | output | 2 | Auxiliary select field |
| hpf_en | output | 1 | High-pass enable |
| fs_sel | output | 2 | Range select |
| odr_sel | output | 3 | Data-rate select |
| dev_active | output | 1 | Active/standby bit |
| dev_ready | output | 1 | Ready bit |
| fsr_dbl | output | 1 | Range doubling |

## Verification
The checker evaluates several properties on every access:
- the identity value and the zero value returned for undefined addresses;
- both pointer wrap targets after 0x06;
- the pin direction selected by the external-control bit;
- the one-cycle tracking of the synchronized pin by the active bit;
- the stability of control register 0 between writes.

Some behaviour can only be shown by the bench's scenarios, because it depends on history across many accesses. This covers:
- the shadow copy staying frozen while `sample_in` moves during a burst;
- the exact three-edge latency from the pin to `dev_active`;
- a host write to the active bit being ignored under pin control;
- write/readback of the field layouts.

// File: rtl/gyro_regs_pkg.sv
package gyro_regs_pkg;

    localparam int DW = 8;

    localparam logic [7:0] A_STATUS = 8'h00;
    localparam logic [7:0] A_FIRST  = 8'h01;
    localparam logic [7:0] A_IDENT  = 8'h0C;
    localparam logic [7:0] A_CTRL0  = 8'h0D;
    localparam logic [7:0] A_CTRL1  = 8'h13;
    localparam logic [7:0] A_CTRL3  = 8'h15;
    localparam logic [7:0] ID_VALUE = 8'hD6;

    typedef struct packed {
        logic [1:0] bw;
        logic       spiw;
        logic [1:0] aux;
        logic       hpf;
        logic [1:0] fs;
    } ctrl0_t;

    typedef struct packed {
        logic       wrap1;
        logic       extc;
        logic       dbl;
    } ctrl3_t;

    // Next pointer after an access at address a; last is the final data address
    function automatic logic [7:0] ptr_next(logic [7:0] a, logic is_read,
                                            logic wrap1, logic [7:0] last);
        if (is_read && a == last)
            return wrap1 ? A_FIRST : A_STATUS;
        return a + 8'd1;
    endfunction

    function automatic logic addr_known(logic [7:0] a, logic [7:0] last);
        return (a <= last) || a == A_IDENT || a == A_CTRL0 ||
               a == A_CTRL1 || a == A_CTRL3;
    endfunction

endpackage

// File: rtl/gyro_burst_ptr.sv
module gyro_burst_ptr
    import gyro_regs_pkg::*;
#(
    parameter int LAST = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       we,
    input  logic       start,
    input  logic [7:0] addr,
    input  logic       wrap1,
    output logic [7:0] eff_addr,
    output logic [7:0] ptr_q
);
    localparam logic [7:0] LAST_A = 8'(LAST);

    assign eff_addr = start ? addr : ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= A_STATUS;
        else if (en)
            ptr_q <= ptr_next(eff_addr, !we, wrap1, LAST_A);
    end
endmodule

// File: rtl/gyro_pin_sync.sv
module gyro_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= d;
            end
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/gyro_sample_shadow.sv
module gyro_sample_shadow #(
    parameter int NUM_AXES = 3,
    parameter int AXIS_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       capture,
    input  logic [NUM_AXES*AXIS_W-1:0] live,
    output logic [NUM_AXES*AXIS_W-1:0] held
);
    genvar g;
    generate
        for (g = 0; g < NUM_AXES; g++) begin : g_axis
            always_ff @(posedge clk) begin
                if (rst)
                    held[g*AXIS_W +: AXIS_W] <= '0;
                else if (capture)
                    held[g*AXIS_W +: AXIS_W] <= live[g*AXIS_W +: AXIS_W];
            end
        end
    endgenerate
endmodule

// File: rtl/gyro_regbank.sv
module gyro_regbank
    import gyro_regs_pkg::*;
#(
    parameter int NUM_AXES    = 3,
    parameter int AXIS_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_en,
    input  logic                       bus_we,
    input  logic                       bus_start,
    input  logic [7:0]                 bus_addr,
    input  logic [7:0]                 bus_wdata,
    output logic [7:0]                 bus_rdata,
    input  logic [7:0]                 stat_in,
    input  logic [NUM_AXES*AXIS_W-1:0] sample_in,
    input  logic                       irq2_req,
    input  logic                       int2_pin_in,
    output logic                       int2_oe,
    output logic                       int2_out,
    output logic [1:0]                 bw_sel,
    output logic                       spi_wire,
    output logic [1:0]                 aux_sel,
    output logic                       hpf_en,
    output logic [1:0]                 fs_sel,
    output logic [2:0]                 odr_sel,
    output logic                       dev_active,
    output logic                       dev_ready,
    output logic                       fsr_dbl
);
    localparam int         FW     = NUM_AXES * AXIS_W;
    localparam int         NB     = FW / DW;
    localparam logic [7:0] LAST_A = 8'(NB);

    logic [7:0]    eff_addr;
    logic [7:0]    ptr_q;
    logic [FW-1:0] shadow;
    logic          sync_lvl;
    ctrl0_t        c0;
    ctrl3_t        c3;
    logic [2:0]    odr_q;
    logic          ready_q;
    logic          active_q;
    logic [7:0]    rd_byte;
    logic          wr_hit;
    logic          rd_hit;

    assign wr_hit = bus_en && bus_we;
    assign rd_hit = bus_en && !bus_we;

    gyro_burst_ptr #(.LAST(NB)) u_ptr (
        .clk(clk), .rst(rst), .en(bus_en), .we(bus_we), .start(bus_start),
        .addr(bus_addr), .wrap1(c3.wrap1), .eff_addr(eff_addr), .ptr_q(ptr_q)
    );

    gyro_sample_shadow #(.NUM_AXES(NUM_AXES), .AXIS_W(AXIS_W)) u_shadow (
        .clk(clk), .rst(rst), .capture(rd_hit && eff_addr == A_FIRST),
        .live(sample_in), .held(shadow)
    );

    gyro_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(int2_pin_in), .q(sync_lvl)
    );

    // Control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            c0       <= '0;
            c3       <= '0;
            odr_q    <= '0;
            ready_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (wr_hit && eff_addr == A_CTRL0)
                c0 <= ctrl0_t'(bus_wdata);
            if (wr_hit && eff_addr == A_CTRL3) begin
                c3.wrap1 <= bus_wdata[3];
                c3.extc  <= bus_wdata[2];
                c3.dbl   <= bus_wdata[0];
            end
            if (wr_hit && eff_addr == A_CTRL1) begin
                odr_q   <= bus_wdata[4:2];
                ready_q <= bus_wdata[0];
            end
            if (c3.extc)
                active_q <= sync_lvl;
            else if (wr_hit && eff_addr == A_CTRL1)
                active_q <= bus_wdata[1];
        end
    end

    // Read multiplexer
    always_comb begin
        logic [FW-1:0] src;
        int            idx;
        src     = '0;
        idx     = 0;
        rd_byte = '0;
        if (eff_addr == A_STATUS) begin
            rd_byte = stat_in;
        end else if (eff_addr <= LAST_A) begin
            idx     = int'(eff_addr) - 1;
            src     = (eff_addr == A_FIRST) ? sample_in : shadow;
            src     = src >> (DW * (NB - 1 - idx));
            rd_byte = src[DW-1:0];
        end else begin
            case (eff_addr)
                A_IDENT: rd_byte = ID_VALUE;
                A_CTRL0: rd_byte = c0;
                A_CTRL1: rd_byte = {3'b000, odr_q, active_q, ready_q};
                A_CTRL3: rd_byte = {4'b0000, c3.wrap1, c3.extc, 1'b0, c3.dbl};
                default: rd_byte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd_hit)
            bus_rdata <= rd_byte;
    end

    assign int2_oe    = !c3.extc;
    assign int2_out   = c3.extc ? 1'b0 : irq2_req;
    assign bw_sel     = c0.bw;
    assign spi_wire   = c0.spiw;
    assign aux_sel    = c0.aux;
    assign hpf_en     = c0.hpf;
    assign fs_sel     = c0.fs;
    assign odr_sel    = odr_q;
    assign dev_active = active_q;
    assign dev_ready  = ready_q;
    assign fsr_dbl    = c3.dbl;
endmodule

// File: rtl/gyro_regbank_chk.sv
module gyro_regbank_chk
    import gyro_regs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_en,
    input logic       bus_we,
    input logic [7:0] eff_addr,
    input logic [7:0] ptr_q,
    input logic [7:0] bus_rdata,
    input logic       wrap1,
    input logic       ext_en,
    input logic       sync_lvl,
    input logic       dev_active,
    input logic       int2_oe,
    input logic       int2_out,
    input logic       irq2_req,
    input logic [7:0] cfg0
);
    localparam logic [7:0] LAST_A = 8'h06;

    AST_IDENT_VALUE: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && eff_addr == A_IDENT) |=> bus_rdata == ID_VALUE); // R2

    AST_WRAP_STATUS: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && eff_addr == LAST_A && !wrap1) |=> ptr_q == A_STATUS); // R4

    AST_WRAP_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && eff_addr == LAST_A && wrap1) |=> ptr_q == A_FIRST); // R5

    AST_CFG0_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we && eff_addr == A_CTRL0) |=> $stable(cfg0)); // R7

    AST_PIN_INPUT: assert property (@(posedge clk) disable iff (rst)
        ext_en |-> !int2_oe); // R9

    AST_PIN_TRACK: assert property (@(posedge clk) disable iff (rst)
        ext_en |=> dev_active == $past(sync_lvl)); // R9

    AST_PIN_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !ext_en |-> (int2_oe && int2_out == irq2_req)); // R10

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && !addr_known(eff_addr, LAST_A)) |=> bus_rdata == 8'h00); // R11
endmodule

bind gyro_regbank gyro_regbank_chk u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .eff_addr(eff_addr), .ptr_q(ptr_q), .bus_rdata(bus_rdata),
    .wrap1(c3.wrap1), .ext_en(c3.extc), .sync_lvl(sync_lvl),
    .dev_active(dev_active), .int2_oe(int2_oe), .int2_out(int2_out),
    .irq2_req(irq2_req), .cfg0(c0)
);

// File: tb/sim_gyro_regbank.sv
module sim_gyro_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_start = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  stat_in = '0;
    logic [47:0] sample_in = '0;
    logic        irq2_req = 1'b0, int2_pin_in = 1'b0;
    logic        int2_oe, int2_out, spi_wire, hpf_en, dev_active, dev_ready, fsr_dbl;
    logic [1:0]  bw_sel, aux_sel, fs_sel;
    logic [2:0]  odr_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gyro_regbank u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_in(stat_in), .sample_in(sample_in), .irq2_req(irq2_req),
        .int2_pin_in(int2_pin_in), .int2_oe(int2_oe), .int2_out(int2_out),
        .bw_sel(bw_sel), .spi_wire(spi_wire), .aux_sel(aux_sel), .hpf_en(hpf_en),
        .fs_sel(fs_sel), .odr_sel(odr_sel), .dev_active(dev_active),
        .dev_ready(dev_ready), .fsr_dbl(fsr_dbl)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic st, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_start = st; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0; bus_start = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic st, input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_start = st; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_start = 1'b0;
    endtask

    function automatic logic [7:0] nxt(input logic [7:0] a, input logic w1);
        if (a == 8'h06) return w1 ? 8'h01 : 8'h00;
        return a + 8'd1;
    endfunction

    function automatic logic [7:0] byte_of(input logic [47:0] s, input logic [7:0] a);
        return s[(6 - int'(a)) * 8 +: 8];
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [7:0]  a;
        logic [47:0] snap;
        logic        w1;
        void'($urandom(32'd4917));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b1, 8'h0D, d); chk("R1 ctrl0", d, 8'h00);
        rd(1'b1, 8'h13, d); chk("R1 ctrl1", d, 8'h00);
        rd(1'b1, 8'h15, d); chk("R1 ctrl3", d, 8'h00);
        chk("R1 pins", {int2_oe, dev_active, fsr_dbl, odr_sel}, {1'b1, 1'b0, 1'b0, 3'b000});

        // R2 identity
        rd(1'b1, 8'h0C, d); chk("R2 ident", d, 8'hD6);

        // R3 layout, single reads
        sample_in = 48'h1234_ABCD_80F7; stat_in = 8'h5A;
        rd(1'b1, 8'h00, d); chk("R3 status", d, 8'h5A);
        rd(1'b1, 8'h01, d); chk("R3 x hi", d, 8'h12);
        rd(1'b0, 8'h00, d); chk("R3 x lo", d, 8'h34);
        rd(1'b1, 8'h05, d); chk("R3 z hi", d, 8'h80);
        rd(1'b0, 8'h00, d); chk("R3 z lo", d, 8'hF7);
        rd(1'b0, 8'h00, d); chk("R4 wrap to status", d, 8'h5A);

        // R7 ctrl0 fields
        wr(1'b1, 8'h0D, 8'b10_1_01_1_10);
        rd(1'b1, 8'h0D, d); chk("R7 ctrl0 readback", d, 8'hAE);
        chk("R7 fields", {bw_sel, spi_wire, aux_sel, hpf_en, fs_sel}, 9'b10_1_01_1_10);
        wr(1'b1, 8'h0E, 8'hFF);
        chk("R7 hold", {bw_sel, spi_wire, aux_sel, hpf_en, fs_sel}, 9'b10_1_01_1_10);

        // R12 ctrl1
        wr(1'b1, 8'h13, 8'hFD);
        rd(1'b1, 8'h13, d); chk("R12 ctrl1 readback", d, 8'h1D);
        chk("R12 odr/ready/active", {odr_sel, dev_ready, dev_active}, {3'b111, 1'b1, 1'b0});
        wr(1'b1, 8'h13, 8'h08);
        chk("R12 odr", odr_sel, 3'b010);

        // R8 ctrl3 unused bits
        wr(1'b1, 8'h15, 8'hFB);
        rd(1'b1, 8'h15, d); chk("R8 ctrl3 readback", d, 8'h09);
        chk("R8 fsr_dbl", fsr_dbl, 1'b1);
        wr(1'b1, 8'h15, 8'h00);

        // R11 read-only and undefined
        wr(1'b1, 8'h0C, 8'h55);
        rd(1'b1, 8'h0C, d); chk("R11 ident write ignored", d, 8'hD6);
        wr(1'b1, 8'h20, 8'h77);
        rd(1'b1, 8'h20, d); chk("R11 undefined read", d, 8'h00);
        wr(1'b1, 8'h00, 8'h11);
        rd(1'b1, 8'h00, d); chk("R11 status write ignored", d, 8'h5A);
        rd(1'b1, 8'hFF, d); chk("R11 undefined top", d, 8'h00);
        wr(1'b1, 8'h12, 8'h33);
        rd(1'b1, 8'h0D, d); chk("R11 neighbour unchanged", d, 8'hAE);

        // R4 write auto-increment: 0x0D then 0x0E (ignored)
        wr(1'b1, 8'h0D, 8'h01);
        wr(1'b0, 8'h00, 8'h02);
        rd(1'b1, 8'h0D, d); chk("R4 write increment", d, 8'h01);

        // R4 R5 R6 random bursts
        for (int it = 0; it < 24; it++) begin
            w1 = 1'($urandom);
            wr(1'b1, 8'h15, {4'b0, w1, 3'b000});
            stat_in   = 8'($urandom);
            sample_in = {$urandom, 16'($urandom)};
            snap = sample_in;
            a = 8'h00;
            for (int k = 0; k < 15; k++) begin
                rd(k == 0, a, d);
                if (a == 8'h00) chk("R4 burst status", d, stat_in);
                else if (a == 8'h01) chk(w1 ? "R5 burst x hi" : "R4 burst x hi", d, byte_of(snap, a));
                else chk("R6 burst shadow", d, byte_of(snap, a));
                if (a == 8'h01) snap = snap;
                a = nxt(a, w1);
                stat_in   = 8'($urandom);
                sample_in = {$urandom, 16'($urandom)};
                if (a == 8'h01) snap = sample_in;
            end
        end

        // R6 directed: sample changes after X high read
        wr(1'b1, 8'h15, 8'h00);
        sample_in = 48'hAAAA_BBBB_CCCC;
        rd(1'b1, 8'h01, d); chk("R6 x hi live", d, 8'hAA);
        sample_in = 48'h1111_2222_3333;
        rd(1'b0, 8'h00, d); chk("R6 x lo held", d, 8'hAA);
        rd(1'b0, 8'h00, d); chk("R6 y hi held", d, 8'hBB);

        // R9 external control
        int2_pin_in = 1'b0;
        wr(1'b1, 8'h13, 8'h02);
        chk("R10 host active", dev_active, 1'b1);
        wr(1'b1, 8'h15, 8'h04);
        repeat (4) @(negedge clk);
        chk("R9 pin input", int2_oe, 1'b0);
        chk("R9 follows low pin", dev_active, 1'b0);
        int2_pin_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 latency not yet", dev_active, 1'b0);
        @(negedge clk);
        chk("R9 latency three edges", dev_active, 1'b1);
        wr(1'b1, 8'h13, 8'h00);
        rd(1'b1, 8'h13, d); chk("R9 write ignored", d, 8'h02);
        chk("R9 port still active", dev_active, 1'b1);
        int2_pin_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 follows pin down", dev_active, 1'b0);

        // R10 back to output mode
        wr(1'b1, 8'h15, 8'h00);
        irq2_req = 1'b1;
        @(negedge clk);
        chk("R10 pin output", {int2_oe, int2_out}, 2'b11);
        int2_pin_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 pin no effect", dev_active, 1'b0);
        wr(1'b1, 8'h13, 8'h02);
        chk("R10 host write", dev_active, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule